// File: doc/BRIEF.md
# Four-Channel Command-Register Timer

This block is a memory-mapped timer holding four independent 32-bit counting channels. Every channel advances only on cycles where its own tick-enable input is high, so each channel can count at a different rate derived elsewhere. Software controls a channel through write-only command offsets (clear, start, stop) and a write-only mode register. It observes the channel through a packed status word, the live count and the programmed limit. Each channel raises its own interrupt line.

When a running channel's count arrives at its limit, the channel latches a pending flag. In continuous mode the following tick restarts the count at zero, so a limit of all ones gives a free-running 32-bit counter that wraps. In one-shot mode the channel stops there and goes idle. A single shared register carries a clock-request enable bit that is brought out of the block. The register bus is a single-cycle bus: writes take effect at the next clock edge and read data is returned combinationally in the same cycle.

Top module: `quad_cmd_timer`

## Requirements
- R1: After reset every channel has count 0, limit 0, is stopped in continuous mode with its interrupt disabled and nothing pending, so its status reads 0x01. All irq lines and clk_req are low.
- R2: Channel n occupies addresses n*0x40 to n*0x40+0x3F. Its offsets are: clear 0x00, start 0x04, stop 0x08, mode 0x0C, status 0x10, count 0x14, limit 0x18, interrupt enable 0x1C, acknowledge 0x20. A write to one channel leaves every other channel unchanged.
- R3: A write to the clear, start or stop offset performs its command whatever data value is written.
- R4: A started channel adds one to its count at each clock edge where its tick input is high. A stopped channel, or one whose tick is low, holds its count.
- R5: On a counting edge, a count equal to the limit becomes 0 and any other count increments. When the new count equals the limit, pending is set. In continuous mode (mode bit 0 = 0) counting then goes on.
- R6: In one-shot mode (mode bit 0 = 1), the edge that brings the count to the limit also stops the channel. The count then holds at the limit.
- R7: Status reads as {24'b0, pending, irq_enable, one_shot, started, state[3:0]}. The state field is 2 while the channel is started and 1 while it is stopped.
- R8: Bit 0 of a write to the interrupt-enable offset sets or clears the enable. irq[n] is high exactly while channel n is both pending and enabled.
- R9: A write to the acknowledge offset with bit 7 set clears pending. If bit 7 is clear, the write has no effect. If the counting edge of the same cycle sets pending, pending stays set.
- R10: The clear command sets the count to 0 and clears pending. It leaves the started flag, the mode and the limit unchanged.
- R11: Reads from the write-only offsets, from unmapped offsets, or with bus_rd low return 0. Writes to the status and count offsets change nothing.
- R12: Bit 0 of the shared register at 0x100 is readable and writable, resets to 0, and drives clk_req.
- R13: Reprogramming a channel is done in this order: interrupt off, stop, clear, limit 1, one-shot mode, interrupt on, start. After this sequence a single tick sets pending and stops the channel with count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 4 | Per-channel count enable |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | 4 | Per-channel interrupt, pending AND enable |
| clk_req | output | 1 | Shared clock-request enable bit |

## Verification
A write on the bus changes state at the rising edge that ends its cycle. Its effect on status, count and irq is therefore visible from the next cycle on, and a tick edge that reaches the limit raises pending and irq in the cycle right after it. Read data depends combinationally on the registered state, so it is sampled within the same cycle that bus_rd is raised. The bench drives inputs just after each falling edge and samples just before the next rising edge. Its behavioural reference model advances once per rising edge and is compared with irq, clk_req and any active read on every falling edge. Directed checks with hand-derived constants cover each requirement, including a tick and an acknowledge that land in the same cycle.

// File: rtl/qct_pkg.sv
package qct_pkg;

    localparam logic [5:0] OFS_CLEAR  = 6'h00;
    localparam logic [5:0] OFS_START  = 6'h04;
    localparam logic [5:0] OFS_STOP   = 6'h08;
    localparam logic [5:0] OFS_MODE   = 6'h0C;
    localparam logic [5:0] OFS_STATUS = 6'h10;
    localparam logic [5:0] OFS_COUNT  = 6'h14;
    localparam logic [5:0] OFS_LIMIT  = 6'h18;
    localparam logic [5:0] OFS_IRQEN  = 6'h1C;
    localparam logic [5:0] OFS_ACK    = 6'h20;

    localparam int STRIDE_W   = 6;
    localparam int SHARED_OFS = 'h100;
    localparam int ACK_BIT    = 7;

    localparam logic [3:0] ST_IDLE   = 4'd1;
    localparam logic [3:0] ST_ACTIVE = 4'd2;

    typedef struct packed {
        logic clear;
        logic start;
        logic stop;
        logic mode;
        logic limit;
        logic irqen;
        logic ack;
    } chan_cmd_t;

endpackage

// File: rtl/qct_decode.sv
module qct_decode
    import qct_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output chan_cmd_t         cmd_o [NCH],
    output logic              in_chan_o,
    output logic              shared_o,
    output logic [5:0]        ofs_o,
    output logic [(NCH>1 ? $clog2(NCH) : 1)-1:0] ch_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    assign ofs_o     = addr_i[STRIDE_W-1:0];
    assign ch_o      = addr_i[STRIDE_W +: CH_W];
    assign in_chan_o = (addr_i < ADDR_W'(NCH * (1 << STRIDE_W)));
    assign shared_o  = (addr_i == ADDR_W'(SHARED_OFS));

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        always_comb begin
            cmd_o[g] = '0;
            if (wr_i && in_chan_o && (ch_o == CH_W'(g))) begin
                case (ofs_o)
                    OFS_CLEAR: cmd_o[g].clear = 1'b1;
                    OFS_START: cmd_o[g].start = 1'b1;
                    OFS_STOP:  cmd_o[g].stop  = 1'b1;
                    OFS_MODE:  cmd_o[g].mode  = 1'b1;
                    OFS_LIMIT: cmd_o[g].limit = 1'b1;
                    OFS_IRQEN: cmd_o[g].irqen = 1'b1;
                    OFS_ACK:   cmd_o[g].ack   = 1'b1;
                    default:   cmd_o[g]       = '0;
                endcase
            end
        end

        // Writes aimed elsewhere never reach this channel (R2)
        assert_no_foreign_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_i || shared_o) |-> (cmd_o[g] == '0));
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import qct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  chan_cmd_t        cmd_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             irq_o,
    output logic [7:0]       status_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             run;
        logic             oneshot;
        logic             ie;
        logic             pend;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic [CNT_W-1:0] step;
    logic             counting;
    logic             hit;

    always_comb begin
        s_d      = s_q;
        counting = s_q.run && tick_i;
        step     = (s_q.cnt == s_q.lim) ? '0 : s_q.cnt + 1'b1;
        hit      = counting && (step == s_q.lim);

        if (counting) begin
            s_d.cnt = step;
            if (hit) begin
                s_d.pend = 1'b1;
                if (s_q.oneshot) s_d.run = 1'b0;
            end
        end
        if (cmd_i.ack && wdata_i[ACK_BIT] && !hit) s_d.pend = 1'b0;
        if (cmd_i.clear) begin
            s_d.cnt  = '0;
            s_d.pend = 1'b0;
        end
        if (cmd_i.start) s_d.run     = 1'b1;
        if (cmd_i.stop)  s_d.run     = 1'b0;
        if (cmd_i.mode)  s_d.oneshot = wdata_i[0];
        if (cmd_i.limit) s_d.lim     = wdata_i;
        if (cmd_i.irqen) s_d.ie      = wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o    = s_q.pend & s_q.ie;
    assign status_o = {s_q.pend, s_q.ie, s_q.oneshot, s_q.run,
                       s_q.run ? ST_ACTIVE : ST_IDLE};
    assign count_o  = s_q.cnt;
    assign limit_o  = s_q.lim;

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !cmd_i.clear) |=> $stable(s_q.cnt));

    assert_pend_from_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pend) |-> $past(s_q.run && tick_i));

    assert_oneshot_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.pend) && $past(s_q.oneshot) && !$past(cmd_i.start)) |-> !s_q.run);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.ack && wdata_i[ACK_BIT] && !(s_q.run && tick_i)) |=> !s_q.pend);

    assert_clear_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.clear |=> (s_q.cnt == '0 && !s_q.pend));

endmodule

// File: rtl/quad_cmd_timer.sv
module quad_cmd_timer
    import qct_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic              clk_req
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    chan_cmd_t         cmd [NCH];
    logic [7:0]        stat [NCH];
    logic [DATA_W-1:0] cnt [NCH];
    logic [DATA_W-1:0] lim [NCH];
    logic              in_chan, shared;
    logic [5:0]        ofs;
    logic [CH_W-1:0]   ch;
    logic              clkreq_d, clkreq_q;
    logic              clkreq_wr;

    qct_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .cmd_o     (cmd),
        .in_chan_o (in_chan),
        .shared_o  (shared),
        .ofs_o     (ofs),
        .ch_o      (ch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        timer_channel #(.CNT_W(DATA_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_en[g]),
            .cmd_i    (cmd[g]),
            .wdata_i  (bus_wdata),
            .irq_o    (irq[g]),
            .status_o (stat[g]),
            .count_o  (cnt[g]),
            .limit_o  (lim[g])
        );
    end

    assign clkreq_wr = bus_wr && shared;

    always_comb begin
        clkreq_d = clkreq_q;
        if (clkreq_wr) clkreq_d = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) clkreq_q <= 1'b0;
        else        clkreq_q <= clkreq_d;
    end

    assign clk_req = clkreq_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (in_chan) begin
                case (ofs)
                    OFS_STATUS: bus_rdata = DATA_W'(stat[ch]);
                    OFS_COUNT:  bus_rdata = cnt[ch];
                    OFS_LIMIT:  bus_rdata = lim[ch];
                    default:    bus_rdata = '0;
                endcase
            end else if (shared) begin
                bus_rdata = DATA_W'(clkreq_q);
            end
        end
    end

    assert_clkreq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clkreq_wr |=> $stable(clk_req));

endmodule

// File: tb/test_quad_cmd_timer.sv
module test_quad_cmd_timer;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_en = '0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        clk_req;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    quad_cmd_timer i_quad_cmd_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq), .clk_req(clk_req)
    );

    // reference model
    logic [31:0] m_cnt [4];
    logic [31:0] m_lim [4];
    bit          m_run [4];
    bit          m_os  [4];
    bit          m_ie  [4];
    bit          m_pnd [4];
    bit          m_clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_cnt[c] = 0; m_lim[c] = 0; m_run[c] = 0;
                m_os[c] = 0; m_ie[c] = 0; m_pnd[c] = 0;
            end
            m_clk = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                bit here;
                bit fired;
                int o;
                here  = bus_wr && (bus_addr < 256) && (int'(bus_addr) / 64 == c);
                o     = int'(bus_addr) % 64;
                fired = 0;
                if (m_run[c] && tick_en[c]) begin
                    if (m_cnt[c] == m_lim[c]) m_cnt[c] = 0;
                    else m_cnt[c] = m_cnt[c] + 1;
                    if (m_cnt[c] == m_lim[c]) begin
                        fired = 1;
                        m_pnd[c] = 1;
                        if (m_os[c]) m_run[c] = 0;
                    end
                end
                if (here) begin
                    case (o)
                        'h00: begin m_cnt[c] = 0; m_pnd[c] = 0; end
                        'h04: m_run[c] = 1;
                        'h08: m_run[c] = 0;
                        'h0C: m_os[c] = bus_wdata[0];
                        'h18: m_lim[c] = bus_wdata;
                        'h1C: m_ie[c] = bus_wdata[0];
                        'h20: if (bus_wdata[7] && !fired) m_pnd[c] = 0;
                        default: ;
                    endcase
                end
            end
            if (bus_wr && bus_addr == 9'h100) m_clk = bus_wdata[0];
        end
    end

    function automatic logic [31:0] exp_rd(logic [8:0] a);
        int c, o;
        c = int'(a) / 64;
        o = int'(a) % 64;
        if (a < 256) begin
            case (o)
                'h10: return {24'h0, m_pnd[c], m_ie[c], m_os[c], m_run[c],
                              m_run[c] ? 4'd2 : 4'd1};
                'h14: return m_cnt[c];
                'h18: return m_lim[c];
                default: return 0;
            endcase
        end
        if (a == 9'h100) return {31'b0, m_clk};
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act === exp) n_pass++;
        else $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] mi;
            for (int c = 0; c < 4; c++) mi[c] = m_pnd[c] & m_ie[c];
            chk("R8 model irq", {28'h0, irq}, {28'h0, mi});
            chk("R12 model clk_req", {31'h0, clk_req}, {31'h0, m_clk});
            if (bus_rd) chk("R11 model rdata", bus_rdata, exp_rd(bus_addr));
            else chk("R11 rdata idle", bus_rdata, 32'h0);
        end
    end

    function automatic logic [8:0] A(int c, int o);
        return 9'(c * 64 + o);
    endfunction

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk); #0.5;
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #0.5;
        bus_wr = 0;
    endtask

    task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
        @(negedge clk); #0.5;
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(logic [3:0] mask, int n);
        @(negedge clk); #0.5;
        tick_en = mask;
        repeat (n) @(posedge clk);
        @(negedge clk); #0.5;
        tick_en = '0;
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #0.5;
        rst_n = 1;

        // R1: reset state
        @(negedge clk); #1;
        chk("R1 irq", {28'h0, irq}, 32'h0);
        chk("R1 clk_req", {31'h0, clk_req}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(A(c, 'h10), 32'h01, "R1 status");
            rd(A(c, 'h14), 32'h0, "R1 count");
            rd(A(c, 'h18), 32'h0, "R1 limit");
        end

        // R2: per-channel limit registers
        for (int c = 0; c < 4; c++) wr(A(c, 'h18), 32'h100 + c);
        for (int c = 0; c < 4; c++) rd(A(c, 'h18), 32'h100 + c, "R2 limit readback");

        // R12: shared clock request
        wr(9'h100, 32'h1);
        rd(9'h100, 32'h1, "R12 readback");
        chk("R12 clk_req pin", {31'h0, clk_req}, 32'h1);

        // R11: write-only / unmapped reads, read-only writes
        rd(A(0, 'h0C), 32'h0, "R11 mode reads zero");
        rd(A(0, 'h04), 32'h0, "R11 start reads zero");
        rd(A(0, 'h24), 32'h0, "R11 unmapped offset");
        rd(9'h104, 32'h0, "R11 unmapped shared");
        wr(A(0, 'h10), 32'hFF);
        rd(A(0, 'h10), 32'h01, "R11 status write ignored");
        wr(A(0, 'h14), 32'h5);
        rd(A(0, 'h14), 32'h0, "R11 count write ignored");

        // R3/R4: start with arbitrary data, count ticks
        wr(A(0, 'h18), 32'd5);
        wr(A(0, 'h04), 32'hDEAD);
        rd(A(0, 'h10), 32'h12, "R3 start any data");
        ticks(4'b0001, 3);
        rd(A(0, 'h14), 32'd3, "R4 count after 3 ticks");
        repeat (4) @(posedge clk);
        rd(A(0, 'h14), 32'd3, "R4 hold with tick low");

        // R5/R8: reach limit, pending, wrap to zero
        wr(A(0, 'h1C), 32'h1);
        ticks(4'b0001, 2);
        rd(A(0, 'h14), 32'd5, "R5 count at limit");
        rd(A(0, 'h10), 32'hD2, "R7 status pending");
        chk("R8 irq high", {31'h0, irq[0]}, 32'h1);
        ticks(4'b0001, 1);
        rd(A(0, 'h14), 32'd0, "R5 wrap to zero");

        // R9: acknowledge
        wr(A(0, 'h20), 32'h7F);
        rd(A(0, 'h10), 32'hD2, "R9 ack without bit7");
        wr(A(0, 'h20), 32'h80);
        rd(A(0, 'h10), 32'h52, "R9 ack clears");
        chk("R8 irq low", {31'h0, irq[0]}, 32'h0);

        // R3/R4: stop with arbitrary data
        wr(A(0, 'h08), 32'hFFFF_FFFF);
        rd(A(0, 'h10), 32'h41, "R3 stop any data");
        ticks(4'b0001, 3);
        rd(A(0, 'h14), 32'd0, "R4 stopped holds");

        // R10: clear command
        wr(A(0, 'h04), 32'h0);
        ticks(4'b0001, 5);
        rd(A(0, 'h10), 32'hD2, "R10 pending before clear");
        wr(A(0, 'h00), 32'h1234);
        rd(A(0, 'h14), 32'd0, "R10 count cleared");
        rd(A(0, 'h10), 32'h52, "R10 pending cleared run kept");

        // R13/R6: reprogramming order, one-shot of 1
        wr(A(2, 'h1C), 32'h0);
        wr(A(2, 'h08), 32'h0);
        wr(A(2, 'h00), 32'h0);
        wr(A(2, 'h18), 32'h1);
        wr(A(2, 'h0C), 32'h1);
        wr(A(2, 'h1C), 32'h1);
        wr(A(2, 'h04), 32'h0);
        rd(A(2, 'h10), 32'h72, "R13 armed status");
        ticks(4'b0100, 1);
        rd(A(2, 'h14), 32'd1, "R13 count after one tick");
        rd(A(2, 'h10), 32'hE1, "R6 stopped pending");
        chk("R13 irq", {31'h0, irq[2]}, 32'h1);
        ticks(4'b0100, 3);
        rd(A(2, 'h14), 32'd1, "R6 count holds");

        // R9: event and acknowledge in the same cycle
        wr(A(3, 'h18), 32'd2);
        wr(A(3, 'h04), 32'h0);
        ticks(4'b1000, 1);
        @(negedge clk); #0.5;
        tick_en = 4'b1000; bus_rd = 0; bus_wr = 1;
        bus_addr = A(3, 'h20); bus_wdata = 32'h80;
        @(negedge clk); #0.5;
        tick_en = 0; bus_wr = 0;
        rd(A(3, 'h10), 32'h92, "R9 event beats ack");
        wr(A(3, 'h20), 32'h80);
        rd(A(3, 'h10), 32'h12, "R9 later ack clears");

        // R2/R7: untouched channel, mode bit in status
        rd(A(1, 'h14), 32'd0, "R2 channel 1 untouched");
        wr(A(1, 'h0C), 32'h1);
        rd(A(1, 'h10), 32'h21, "R7 one-shot bit");

        @(negedge clk); #0.5;
        bus_rd = 0;
        repeat (2) @(posedge clk);
        summary();
    end

endmodule